// File: doc/BRIEF.md
# Stuck-High Occupancy Episode Detector

This block looks at the per-event hit count of one readout chip with 128 discriminator channels. If a bit in the chip's threshold register is corrupted, the threshold can fall below the baseline, and the chip then reports nearly every channel as hit on every event. The block finds these stuck episodes. It keeps a running sum of the hit counts from the ten most recently accepted events. It opens an episode when the ten-event average climbs above a programmable start level, and it closes the episode only when the average drops under a fixed lower level of 20. The gap between the two levels keeps a noisy average from toggling the state.

Each episode that opens produces a one-cycle request for a full chip reset. The block also counts episodes within the current run. A chip that opens a second episode in the same run is marked excluded until the next run begins.

Hit counts arrive on a valid/ready stream. The block never applies back-pressure while a run is in progress. It lowers `cnt_ready` only in a cycle where `run_start` is high, and the count offered in that cycle is dropped. Comparisons are made against ten times each level, so no division is needed.

Top module: `occ_upset_detector`

## Requirements
- R1: `cnt_ready` is high in every cycle where `run_start` is low and low in every cycle where `run_start` is high. A count is accepted only at a rising edge where both `cnt_valid` and `cnt_ready` are high.
- R2: An episode opens at the edge that accepts a count when two conditions hold: at least 10 counts have been accepted, and the sum of the last 10 accepted counts is strictly greater than 10 times the start level. `in_episode` is high from the cycle after that edge.
- R3: No episode can open until 10 counts have been accepted since the last reset or `run_start`.
- R4: An open episode closes at an accepting edge where the 10-count sum is below 200. A sum of exactly 200 keeps the episode open.
- R5: `chip_reset_req` is high for exactly the one cycle after each edge that opens an episode, and this includes episodes after the first.
- R6: `excluded` goes high when a second episode opens within the same run. It then stays high until `run_start` or reset.
- R7: `run_start` clears the history window, the count of accepted samples, `in_episode`, `excluded` and the per-run episode count. A count offered in the same cycle has no effect.
- R8: A pulse on `thr_wr` loads `thr_val` as the start level for later accepting edges. A sum equal to 10 times the start level does not open an episode.
- R9: Reset (`rst_n` low) clears everything that `run_start` clears and also sets the start level back to 100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_start | input | 1 | Pulse that begins a new run |
| thr_wr | input | 1 | Load strobe for the start level |
| thr_val | input | 8 | New start level (average hits per event) |
| cnt_valid | input | 1 | A hit count is offered |
| cnt_ready | output | 1 | The block accepts the offered count |
| cnt_data | input | 8 | Hits in one event, 0 to 128 |
| in_episode | output | 1 | The chip is in a stuck high-occupancy episode |
| excluded | output | 1 | More than one episode has opened in this run |
| chip_reset_req | output | 1 | One-cycle full reset request when an episode opens |

## Verification
The assertions take for granted that no hit count is above 128, because the bound on the window sum and the behaviour of the close level both depend on it. They also take for granted that `rst_n` and `run_start` are the only ways to clear the state. Every count the stimulus offers, whether directed or random, is drawn from 0 to 128. The stimulus starts each new run only through `run_start` and sometimes asserts it while a count is offered, so the rule that such a count is dropped is tested. The random phase mixes idle cycles, run starts and changes to the start level, and a queue-based model of the window checks the result.

// File: rtl/occ_pkg.sv
package occ_pkg;
  localparam int unsigned OCC_CHANNELS  = 128;
  localparam int unsigned OCC_DEPTH     = 10;
  localparam int unsigned OCC_END_AVG   = 20;
  localparam int unsigned OCC_START_DEF = 100;

  typedef enum logic {
    EP_IDLE   = 1'b0,
    EP_ACTIVE = 1'b1
  } ep_state_e;
endpackage

// File: rtl/occ_window.sv
module occ_window #(
  parameter int CW    = 8,
  parameter int SW    = 11,
  parameter int DEPTH = 10,
  parameter int FW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [CW-1:0] din,
  output logic [SW-1:0] nxt_sum,
  output logic          nxt_full,
  output logic [SW-1:0] sum_q,
  output logic [FW-1:0] fill_q
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [CW-1:0] hist [DEPTH];
  logic [PW-1:0] wp;

  // the entry under wp is the oldest sample, the one leaving the window
  assign nxt_sum  = sum_q + SW'(din) - SW'(hist[wp]);
  assign nxt_full = (fill_q >= FW'(DEPTH - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q  <= '0;
      wp     <= '0;
      fill_q <= '0;
      for (int i = 0; i < DEPTH; i++) hist[i] <= '0;
    end else if (clr) begin
      sum_q  <= '0;
      wp     <= '0;
      fill_q <= '0;
      for (int i = 0; i < DEPTH; i++) hist[i] <= '0;
    end else if (push) begin
      hist[wp] <= din;
      wp       <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      sum_q    <= nxt_sum;
      if (fill_q != FW'(DEPTH)) fill_q <= fill_q + 1'b1;
    end
  end
endmodule

// File: rtl/occ_episode.sv
module occ_episode
  import occ_pkg::*;
#(
  parameter int SW        = 11,
  parameter int LW        = 12,
  parameter int CLOSE_LIM = 200
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          upd,
  input  logic [SW-1:0] sum,
  input  logic          full,
  input  logic [LW-1:0] open_lim,
  output logic          active,
  output logic          excl,
  output logic          open_pulse
);
  ep_state_e  st;
  logic [1:0] n_ep;
  logic       do_open, do_close;

  always_comb begin
    do_close = upd && (st == EP_ACTIVE) && (sum < SW'(CLOSE_LIM));
    do_open  = upd && (st == EP_IDLE) && full && (LW'(sum) > open_lim);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= EP_IDLE;
      n_ep       <= '0;
      excl       <= 1'b0;
      open_pulse <= 1'b0;
    end else if (clr) begin
      st         <= EP_IDLE;
      n_ep       <= '0;
      excl       <= 1'b0;
      open_pulse <= 1'b0;
    end else begin
      open_pulse <= do_open;
      if (do_close)     st <= EP_IDLE;
      else if (do_open) st <= EP_ACTIVE;
      if (do_open) begin
        if (n_ep != 2'd2) n_ep <= n_ep + 1'b1;
        if (n_ep != 2'd0) excl <= 1'b1;
      end
    end
  end

  assign active = (st == EP_ACTIVE);
endmodule

// File: rtl/occ_upset_detector.sv
module occ_upset_detector
  import occ_pkg::*;
#(
  parameter int CHANNELS  = OCC_CHANNELS,
  parameter int DEPTH     = OCC_DEPTH,
  parameter int END_AVG   = OCC_END_AVG,
  parameter int START_DEF = OCC_START_DEF,
  parameter int CW        = $clog2(CHANNELS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_start,
  input  logic          thr_wr,
  input  logic [CW-1:0] thr_val,
  input  logic          cnt_valid,
  output logic          cnt_ready,
  input  logic [CW-1:0] cnt_data,
  output logic          in_episode,
  output logic          excluded,
  output logic          chip_reset_req
);
  localparam int SW = $clog2(CHANNELS * DEPTH + 1);
  localparam int FW = $clog2(DEPTH + 1);
  localparam int LW = $clog2(((2 ** CW) - 1) * DEPTH + 1);

  logic [CW-1:0] thr_q;
  logic [LW-1:0] open_lim;
  logic [SW-1:0] nxt_sum, win_sum;
  logic [FW-1:0] win_fill;
  logic          nxt_full, accept;

  assign cnt_ready = !run_start;
  assign accept    = cnt_valid && cnt_ready;
  assign open_lim  = LW'(thr_q) * LW'(DEPTH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      thr_q <= CW'(START_DEF);
    else if (thr_wr) thr_q <= thr_val;
  end

  occ_window #(.CW(CW), .SW(SW), .DEPTH(DEPTH), .FW(FW)) u_win (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (run_start),
    .push    (accept),
    .din     (cnt_data),
    .nxt_sum (nxt_sum),
    .nxt_full(nxt_full),
    .sum_q   (win_sum),
    .fill_q  (win_fill)
  );

  occ_episode #(.SW(SW), .LW(LW), .CLOSE_LIM(END_AVG * DEPTH)) u_ep (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (run_start),
    .upd       (accept),
    .sum       (nxt_sum),
    .full      (nxt_full),
    .open_lim  (open_lim),
    .active    (in_episode),
    .excl      (excluded),
    .open_pulse(chip_reset_req)
  );
endmodule

// File: rtl/occ_upset_chk.sv
module occ_upset_chk #(
  parameter int CHANNELS = 128,
  parameter int DEPTH    = 10,
  parameter int END_AVG  = 20,
  parameter int SW       = 11,
  parameter int FW       = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run_start,
  input logic          in_episode,
  input logic          excluded,
  input logic          chip_reset_req,
  input logic [SW-1:0] win_sum,
  input logic [FW-1:0] win_fill
);
  // R2
  sum_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_sum <= SW'(CHANNELS * DEPTH));

  // R3
  full_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chip_reset_req |-> (win_fill == FW'(DEPTH)));

  // R4
  close_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(in_episode) && !$past(run_start)) |-> (win_sum < SW'(END_AVG * DEPTH)));

  // R5
  open_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_episode) |-> chip_reset_req);

  // R5
  pulse_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chip_reset_req |-> in_episode);

  // R6
  excl_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(excluded) |-> chip_reset_req);

  // R6
  excl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (excluded && !run_start) |=> excluded);

  // R7
  run_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_start |=> (!in_episode && !excluded && !chip_reset_req));
endmodule

bind occ_upset_detector occ_upset_chk #(
  .CHANNELS(CHANNELS), .DEPTH(DEPTH), .END_AVG(END_AVG), .SW(SW), .FW(FW)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .run_start     (run_start),
  .in_episode    (in_episode),
  .excluded      (excluded),
  .chip_reset_req(chip_reset_req),
  .win_sum       (win_sum),
  .win_fill      (win_fill)
);

// File: tb/sim_occ_upset_detector.sv
`timescale 1ns/1ps
module sim_occ_upset_detector;
  logic       clk = 1'b0;
  logic       rst_n, run_start, thr_wr, cnt_valid;
  logic [7:0] thr_val, cnt_data;
  logic       cnt_ready, in_episode, excluded, chip_reset_req;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  occ_upset_detector u0 (
    .clk(clk), .rst_n(rst_n), .run_start(run_start), .thr_wr(thr_wr),
    .thr_val(thr_val), .cnt_valid(cnt_valid), .cnt_ready(cnt_ready),
    .cnt_data(cnt_data), .in_episode(in_episode), .excluded(excluded),
    .chip_reset_req(chip_reset_req)
  );

  // behavioural reference
  int q[$];
  bit m_ep, m_exc, m_pulse;
  int m_nep;
  int m_thr = 100;

  always @(posedge clk) begin
    int s;
    if (!rst_n) begin
      q.delete(); m_ep = 0; m_exc = 0; m_pulse = 0; m_nep = 0; m_thr = 100;
    end else if (run_start) begin
      q.delete(); m_ep = 0; m_exc = 0; m_pulse = 0; m_nep = 0;
      if (thr_wr) m_thr = thr_val;
    end else begin
      m_pulse = 0;
      if (cnt_valid) begin
        q.push_back(int'(cnt_data));
        if (q.size() > 10) void'(q.pop_front());
        s = 0;
        foreach (q[i]) s += q[i];
        if (m_ep && s < 200) m_ep = 0;
        else if (!m_ep && q.size() == 10 && s > 10 * m_thr) begin
          m_ep = 1; m_pulse = 1; m_nep++;
          if (m_nep > 1) m_exc = 1;
        end
      end
      if (thr_wr) m_thr = thr_val;
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R1 cnt_ready", int'(cnt_ready), int'(!run_start));
    chk("R2/R4 in_episode", int'(in_episode), int'(m_ep));
    chk("R5 chip_reset_req", int'(chip_reset_req), int'(m_pulse));
    chk("R6 excluded", int'(excluded), int'(m_exc));
  endtask

  task automatic drive(bit v, int d, bit rs);
    cnt_valid = v;
    cnt_data  = 8'(d);
    run_start = rs;
    @(negedge clk);
    if (rst_n) compare_all();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(4 * 100000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 0; run_start = 0; thr_wr = 0; thr_val = 0; cnt_valid = 0; cnt_data = 0;
    repeat (3) drive(0, 0, 0);
    chk("R9 reset in_episode", int'(in_episode), 0);
    chk("R9 reset excluded", int'(excluded), 0);
    chk("R9 reset pulse", int'(chip_reset_req), 0);
    rst_n = 1;
    drive(0, 0, 0);

    // R3: nine full counts are not enough
    repeat (9) drive(1, 128, 0);
    chk("R3 nine samples", int'(in_episode), 0);
    drive(1, 128, 0);
    chk("R2 open on tenth", int'(in_episode), 1);
    chk("R5 pulse on open", int'(chip_reset_req), 1);
    drive(0, 0, 0);
    chk("R5 pulse one cycle", int'(chip_reset_req), 0);

    // R4: sum reaches exactly 200, then 199
    repeat (10) drive(1, 20, 0);
    chk("R4 held at 200", int'(in_episode), 1);
    drive(1, 19, 0);
    chk("R4 closed at 199", int'(in_episode), 0);
    chk("R6 one episode", int'(excluded), 0);

    // R6: second episode in the run
    repeat (10) drive(1, 128, 0);
    chk("R6 second open", int'(in_episode), 1);
    chk("R6 excluded set", int'(excluded), 1);
    repeat (3) drive(0, 0, 0);
    chk("R6 excluded held", int'(excluded), 1);

    // R7: run start with a count offered
    cnt_valid = 1; cnt_data = 128; run_start = 1;
    #1;
    chk("R1 ready low on run start", int'(cnt_ready), 0);
    drive(1, 128, 1);
    chk("R7 cleared episode", int'(in_episode), 0);
    chk("R7 cleared excluded", int'(excluded), 0);
    repeat (9) drive(1, 128, 0);
    chk("R7 dropped sample", int'(in_episode), 0);
    drive(1, 128, 0);
    chk("R7 reopen", int'(in_episode), 1);
    chk("R7 count cleared", int'(excluded), 0);

    // R8: start level 50, equality does not open
    thr_wr = 1; thr_val = 50;
    drive(0, 0, 0);
    thr_wr = 0;
    drive(0, 0, 1);
    repeat (10) drive(1, 50, 0);
    chk("R8 equal sum", int'(in_episode), 0);
    drive(1, 51, 0);
    chk("R8 above level", int'(in_episode), 1);

    // R9: reset mid-run restores level 100
    rst_n = 0;
    drive(0, 0, 0);
    chk("R9 mid reset episode", int'(in_episode), 0);
    rst_n = 1;
    drive(0, 0, 0);
    repeat (10) drive(1, 100, 0);
    chk("R9 level back to 100", int'(in_episode), 0);
    drive(1, 101, 0);
    chk("R9 open above 100", int'(in_episode), 1);

    // mixed traffic checked against the model every cycle
    for (int i = 0; i < 600; i++) begin
      bit v, rs;
      int d;
      v  = ($urandom_range(0, 3) != 0);
      rs = ($urandom_range(0, 99) < 2);
      d  = ($urandom_range(0, 1) != 0) ? $urandom_range(100, 128) : $urandom_range(0, 40);
      thr_wr  = ($urandom_range(0, 49) == 0);
      thr_val = 8'($urandom_range(40, 120));
      drive(v, d, rs);
    end
    thr_wr = 0;
    drive(0, 0, 0);

    summary();
    $finish;
  end
endmodule